// File: doc/BRIEF.md
# Congestion-Aware Minimal Next-Hop Selector

This block chooses the output port for a packet at one router of a two-dimensional mesh. It receives the router's own coordinates, the packet's destination coordinates and a queue-occupancy value from each of the four neighbours. From these inputs it works out which directions shorten the remaining distance. There are none, one or two such directions. When two directions qualify, it takes the one whose neighbour reports the smaller occupancy. This steers traffic away from busy queues and still keeps every hop on a shortest path.

The decision is registered and leaves the block as a one-hot port vector with a valid flag. While the downstream stage holds its ready input low, the decision stays frozen. Neighbour occupancy arrives on plain input buses. Buffering, switching and flow control sit outside this block.

Top module: `mesh_hop_select`

## Requirements
- R1: During reset and in the first cycle after it, `sel_valid` is 0 and `port_sel` is all zero.
- R2: `port_sel` uses bit 0 = Local, bit 1 = North, bit 2 = South, bit 3 = East, bit 4 = West. When `sel_valid` is 1, exactly one bit is set. When `sel_valid` is 0, every bit is 0.
- R3: When the destination equals the current coordinates, the choice is Local.
- R4: When only one coordinate differs, the choice is that axis's productive direction: East if dst_x > cur_x, West if dst_x < cur_x, North if dst_y > cur_y, South if dst_y < cur_y. Pressure has no effect on this choice.
- R5: When both coordinates differ, the choice is the X or Y productive direction whose neighbour pressure is strictly lower. A non-productive direction is never chosen.
- R6: When the two productive directions report equal pressure, the X direction is chosen.
- R7: A request sampled at a rising edge where the output register is free appears on the outputs after that edge. `sel_valid` takes the value of `req_valid`.
- R8: While `sel_valid` is 1 and `out_ready` is 0, `port_sel` and `sel_valid` keep their values whatever the inputs do.
- R9: The output register takes a new sample at any edge where `out_ready` is 1 or `sel_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A routing request is present |
| cur_x | input | X_W | Current router column |
| cur_y | input | Y_W | Current router row |
| dst_x | input | X_W | Destination column |
| dst_y | input | Y_W | Destination row |
| press_n | input | P_W | Queue occupancy reported by the north neighbour |
| press_s | input | P_W | Queue occupancy reported by the south neighbour |
| press_e | input | P_W | Queue occupancy reported by the east neighbour |
| press_w | input | P_W | Queue occupancy reported by the west neighbour |
| out_ready | input | 1 | Downstream accepts the current decision |
| port_sel | output | 5 | One-hot chosen port |
| sel_valid | output | 1 | `port_sel` holds a decision |

## Verification
The bench builds the block with 2-bit coordinates and 2-bit pressure values. At that size every current/destination pair on a 4x4 mesh can be crossed with every combination of the four neighbour pressures. That is 65,536 vectors, each checked against an arithmetic reference. The sweep covers every quadrant, every single-axis case, arrival at the destination, and every strict and tied pressure comparison. Directed sequences before the sweep cover reset, loading into an empty register while ready is low, holding under changing inputs, and dropping the valid flag.

// File: rtl/mesh_sel_pkg.sv
// Package: shared port encoding for the mesh next-hop selector.
// Assumes a five-port router: Local plus four compass neighbours.
package mesh_sel_pkg;
    localparam int NUM_PORTS = 5;
    localparam int NUM_DIRS  = 4;

    // Bit positions in the one-hot port vector
    localparam int LOCAL_B = 0;
    localparam int NORTH_B = 1;
    localparam int SOUTH_B = 2;
    localparam int EAST_B  = 3;
    localparam int WEST_B  = 4;

    // Direction indices for the neighbour pressure array (port bit - 1)
    localparam int DIR_N = 0;
    localparam int DIR_S = 1;
    localparam int DIR_E = 2;
    localparam int DIR_W = 3;

    typedef logic [NUM_PORTS-1:0] port_vec_t;
    typedef logic [NUM_DIRS-1:0]  dir_vec_t;

    // Build a one-hot port vector from a bit position
    function automatic port_vec_t port_onehot(input int b);
        port_vec_t v;
        v = '0;
        v[b] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/mesh_dir_decode.sv
// Module: mesh_dir_decode
// Compares current and destination coordinates and gives, per axis, the
// one productive direction (if any) as a direction mask.
// Assumes unsigned coordinates, X grows eastward and Y grows northward.
module mesh_dir_decode
    import mesh_sel_pkg::*;
#(
    parameter int X_W = 4,
    parameter int Y_W = 4
) (
    input  logic [X_W-1:0] cur_x,
    input  logic [Y_W-1:0] cur_y,
    input  logic [X_W-1:0] dst_x,
    input  logic [Y_W-1:0] dst_y,
    output dir_vec_t       x_mask,
    output dir_vec_t       y_mask,
    output logic           x_move,
    output logic           y_move
);
    // Magnitude compare on each axis to find the productive side
    always_comb begin
        x_mask = '0;
        y_mask = '0;
        if (dst_x > cur_x)      x_mask[DIR_E] = 1'b1;
        else if (dst_x < cur_x) x_mask[DIR_W] = 1'b1;
        if (dst_y > cur_y)      y_mask[DIR_N] = 1'b1;
        else if (dst_y < cur_y) y_mask[DIR_S] = 1'b1;
    end

    // Per-axis flag: this axis still has distance left
    always_comb begin
        x_move = |x_mask;
        y_move = |y_mask;
    end
endmodule

// File: rtl/mesh_press_pick.sv
// Module: mesh_press_pick
// Given the X and Y candidate masks, gathers each candidate's neighbour
// pressure and reports whether the X candidate should win (ties go to X).
// Assumes each mask has at most one bit set.
module mesh_press_pick
    import mesh_sel_pkg::*;
#(
    parameter int P_W = 4
) (
    input  logic [NUM_DIRS-1:0][P_W-1:0] press,
    input  dir_vec_t                     x_mask,
    input  dir_vec_t                     y_mask,
    output logic                         x_wins
);
    logic [NUM_DIRS-1:0][P_W-1:0] x_term;
    logic [NUM_DIRS-1:0][P_W-1:0] y_term;
    logic [P_W-1:0]               x_press;
    logic [P_W-1:0]               y_press;

    // Mask each direction's pressure by the candidate masks
    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_mask
        assign x_term[d] = x_mask[d] ? press[d] : '0;
        assign y_term[d] = y_mask[d] ? press[d] : '0;
    end

    // OR-reduce the masked terms into one pressure per axis
    always_comb begin
        x_press = '0;
        y_press = '0;
        for (int d = 0; d < NUM_DIRS; d++) begin
            x_press = x_press | x_term[d];
            y_press = y_press | y_term[d];
        end
    end

    // X keeps the port unless Y is strictly less loaded
    always_comb begin
        x_wins = (x_press <= y_press);
    end
endmodule

// File: rtl/mesh_sel_reg.sv
// Module: mesh_sel_reg
// Output register for the decision. Loads when empty or when downstream is
// ready, otherwise holds. An empty slot always carries an all-zero vector.
// Assumes synchronous active-low reset.
module mesh_sel_reg
    import mesh_sel_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  port_vec_t in_port,
    input  logic      out_ready,
    output port_vec_t port_sel,
    output logic      sel_valid
);
    logic take;

    // Register is free when it is empty or its content is consumed
    always_comb begin
        take = !sel_valid || out_ready;
    end

    // Capture a new decision or hold the current one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid <= 1'b0;
            port_sel  <= '0;
        end else if (take) begin
            sel_valid <= in_valid;
            port_sel  <= in_valid ? in_port : '0;
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !out_ready) |=> (sel_valid && $stable(port_sel)));

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (port_sel == '0));

    // R2
    onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> ($countones(port_sel) == 1));
endmodule

// File: rtl/mesh_hop_select.sv
// Module: mesh_hop_select
// Congestion-aware minimal next-hop selector for one 2D mesh router.
// Picks Local on arrival, the only productive direction when one axis
// remains, and the less loaded productive direction when both remain.
// Assumes neighbour pressures are queue occupancies, larger = busier.
module mesh_hop_select
    import mesh_sel_pkg::*;
#(
    parameter int X_W = 4,
    parameter int Y_W = 4,
    parameter int P_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [X_W-1:0] cur_x,
    input  logic [Y_W-1:0] cur_y,
    input  logic [X_W-1:0] dst_x,
    input  logic [Y_W-1:0] dst_y,
    input  logic [P_W-1:0] press_n,
    input  logic [P_W-1:0] press_s,
    input  logic [P_W-1:0] press_e,
    input  logic [P_W-1:0] press_w,
    input  logic           out_ready,
    output logic [4:0]     port_sel,
    output logic           sel_valid
);
    dir_vec_t                     x_mask;
    dir_vec_t                     y_mask;
    logic                         x_move;
    logic                         y_move;
    logic                         x_wins;
    logic [NUM_DIRS-1:0][P_W-1:0] press_all;
    port_vec_t                    next_port;
    dir_vec_t                     chosen_dir;
    port_vec_t                    port_q;

    // Gather neighbour pressures in direction-index order
    always_comb begin
        press_all[DIR_N] = press_n;
        press_all[DIR_S] = press_s;
        press_all[DIR_E] = press_e;
        press_all[DIR_W] = press_w;
    end

    mesh_dir_decode #(.X_W(X_W), .Y_W(Y_W)) u_decode (
        .cur_x (cur_x),
        .cur_y (cur_y),
        .dst_x (dst_x),
        .dst_y (dst_y),
        .x_mask(x_mask),
        .y_mask(y_mask),
        .x_move(x_move),
        .y_move(y_move)
    );

    mesh_press_pick #(.P_W(P_W)) u_pick (
        .press (press_all),
        .x_mask(x_mask),
        .y_mask(y_mask),
        .x_wins(x_wins)
    );

    // Choose the direction: single axis skips the pressure compare
    always_comb begin
        if (x_move && y_move) chosen_dir = x_wins ? x_mask : y_mask;
        else if (x_move)      chosen_dir = x_mask;
        else                  chosen_dir = y_mask;
    end

    // Map the direction mask onto the port vector; no direction means Local
    always_comb begin
        next_port = '0;
        if (chosen_dir == '0) next_port[LOCAL_B] = 1'b1;
        else                  next_port[NUM_PORTS-1:1] = chosen_dir;
    end

    mesh_sel_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_port  (next_port),
        .out_ready(out_ready),
        .port_sel (port_q),
        .sel_valid(sel_valid)
    );

    assign port_sel = port_q;

    // R3
    local_on_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!sel_valid || out_ready) && req_valid && cur_x == dst_x && cur_y == dst_y)
        |=> (port_sel == port_onehot(LOCAL_B)));

    // R4
    y_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!sel_valid || out_ready) && req_valid && cur_x == dst_x && cur_y != dst_y)
        |=> (port_sel[NORTH_B] || port_sel[SOUTH_B]));

    // R4
    x_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!sel_valid || out_ready) && req_valid && cur_y == dst_y && cur_x != dst_x)
        |=> (port_sel[EAST_B] || port_sel[WEST_B]));

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_valid || out_ready) |=> (sel_valid == $past(req_valid)));
endmodule

// File: tb/mesh_hop_select_tb.sv
module mesh_hop_select_tb;
    localparam int XW = 2;
    localparam int YW = 2;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [XW-1:0] cur_x = '0, dst_x = '0;
    logic [YW-1:0] cur_y = '0, dst_y = '0;
    logic [PW-1:0] press_n = '0, press_s = '0, press_e = '0, press_w = '0;
    logic          out_ready = 1'b0;
    logic [4:0]    port_sel;
    logic          sel_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    mesh_hop_select #(.X_W(XW), .Y_W(YW), .P_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .press_n(press_n), .press_s(press_s), .press_e(press_e), .press_w(press_w),
        .out_ready(out_ready), .port_sel(port_sel), .sel_valid(sel_valid)
    );

    // Reference: Local=1, North=2, South=4, East=8, West=16
    function automatic logic [4:0] ref_port(int cx, int cy, int dx, int dy,
                                            int pn, int ps, int pe, int pw);
        int xb, yb, xp, yp;
        xb = (dx > cx) ? 3 : (dx < cx) ? 4 : -1;
        yb = (dy > cy) ? 1 : (dy < cy) ? 2 : -1;
        xp = (dx > cx) ? pe : pw;
        yp = (dy > cy) ? pn : ps;
        if (xb < 0 && yb < 0) return 5'd1;
        if (yb < 0) return 5'(1 << xb);
        if (xb < 0) return 5'(1 << yb);
        if (xp <= yp) return 5'(1 << xb);
        return 5'(1 << yb);
    endfunction

    task automatic check(string req, logic [4:0] ap, logic av,
                         logic [4:0] ep, logic ev);
        checks++;
        if (ap !== ep || av !== ev) begin
            fails++;
            $display("FAIL %s: port_sel=%b valid=%b expected port_sel=%b valid=%b",
                     req, ap, av, ep, ev);
        end
    endtask

    task automatic drive(int cx, int cy, int dx, int dy,
                         int pn, int ps, int pe, int pw);
        cur_x = XW'(cx); cur_y = YW'(cy); dst_x = XW'(dx); dst_y = YW'(dy);
        press_n = PW'(pn); press_s = PW'(ps); press_e = PW'(pe); press_w = PW'(pw);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        string tag;
        logic [4:0] exp;
        repeat (3) @(negedge clk);
        check("R1 in reset", port_sel, sel_valid, 5'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", port_sel, sel_valid, 5'd0, 1'b0);

        // R9: empty register loads even with ready low; R3 on arrival
        out_ready = 1'b0;
        req_valid = 1'b1;
        drive(1, 1, 1, 1, 0, 0, 0, 0);
        @(negedge clk);
        check("R9 R3 load into empty", port_sel, sel_valid, 5'd1, 1'b1);

        // R8: hold under changing inputs
        for (int k = 0; k < 3; k++) begin
            drive(0, 0, 3, 3 - k, k, 3, 2, 1);
            req_valid = (k != 1);
            @(negedge clk);
            check("R8 hold", port_sel, sel_valid, 5'd1, 1'b1);
        end

        // R9: ready releases; new decision East (pe=0 < pn=3) per R5
        req_valid = 1'b1;
        out_ready = 1'b1;
        drive(0, 0, 3, 3, 3, 0, 0, 0);
        @(negedge clk);
        check("R9 R5 release", port_sel, sel_valid, 5'd8, 1'b1);

        // R7 / R2: valid drops, vector clears
        req_valid = 1'b0;
        @(negedge clk);
        check("R7 R2 idle", port_sel, sel_valid, 5'd0, 1'b0);

        // Exhaustive sweep with ready high
        req_valid = 1'b1;
        for (int cx = 0; cx < 4; cx++)
        for (int cy = 0; cy < 4; cy++)
        for (int dx = 0; dx < 4; dx++)
        for (int dy = 0; dy < 4; dy++)
        for (int pv = 0; pv < 256; pv++) begin
            int pn, ps, pe, pw;
            pn = pv & 3; ps = (pv >> 2) & 3; pe = (pv >> 4) & 3; pw = (pv >> 6) & 3;
            drive(cx, cy, dx, dy, pn, ps, pe, pw);
            exp = ref_port(cx, cy, dx, dy, pn, ps, pe, pw);
            if (cx == dx && cy == dy) tag = "R3 arrival";
            else if (cx == dx || cy == dy) tag = "R4 single axis";
            else if (((dx > cx) ? pe : pw) == ((dy > cy) ? pn : ps)) tag = "R6 tie";
            else tag = "R5 lower pressure";
            @(negedge clk);
            check(tag, port_sel, sel_valid, exp, 1'b1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule